// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses for one SDRAM read or write burst. A start strobe captures a starting column, a burst length code and a burst type. From the next cycle on, the block presents one column address per clock, with a valid flag and a flag that marks the final beat. Sequential bursts count upward and wrap inside the aligned block the burst length defines. Interleaved bursts visit the columns of that block in the order given by XORing the beat index into the low bits of the start column.

A full-page length runs sequentially across the whole row and keeps going until a terminate strobe stops it. A new start replaces a running burst on any cycle. The combination of full-page length and interleave type is illegal, as is any reserved length code. Such a request starts nothing and raises a one-cycle error flag. The row width is the package constant `COL_W`, which defaults to 8 bits (256 columns).

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `valid_o`, `last_o` and `err_o` are 0.
- R2: A legal start sampled at a clock edge makes `valid_o` 1 after that edge, with `col_o` equal to the captured start column as beat 0. The length codes are 0 = 1 beat, 1 = 2, 2 = 4, 3 = 8 and 7 = full page. `type_i` 0 selects sequential and 1 selects interleaved.
- R3: In a sequential fixed-length burst of length BL, beat n has the start column's bits above log2(BL) unchanged and low log2(BL) bits equal to (start + n) mod BL.
- R4: In an interleaved burst of length BL, beat n has the upper bits of the start column and low log2(BL) bits equal to the start column's low bits XOR n.
- R5: `last_o` is 1 exactly on beat BL-1 of a fixed-length burst. Without a new start, `valid_o` is 0 on the following cycle.
- R6: A full-page burst steps by one modulo 2^COL_W every cycle, never raises `last_o`, and stays valid until it is terminated or replaced.
- R7: A start with length code 7 and the interleave type, or with a reserved code (4, 5 or 6), raises `err_o` for exactly one cycle. It leaves `valid_o` 0 and cancels any running burst.
- R8: A terminate strobe sampled without a start makes `valid_o` 0 from the next cycle.
- R9: A start sampled while a burst runs replaces it at once: the next cycle shows beat 0 of the new burst. A start takes precedence over a simultaneous terminate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| type_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | Column address is valid |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Illegal length and type combination was requested |

## Verification
The bench uses the default 8-bit column width. With that width, full-page bursts started near column 255 wrap through 0 well inside the run, and every length code fits the row. Random starts land on arbitrary columns, so sequential wrap points and every interleave pattern of lengths 2, 4 and 8 come up. Random starts and terminates also overlap running bursts, which exercises replacement and the precedence of a start over a terminate.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int COL_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    typedef struct packed {
        logic [COL_W-1:0] mask;
        logic             page;
        logic             bad;
    } burst_cfg_t;

    typedef struct packed {
        logic             run;
        logic             ilv;
        logic             page;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
    } burst_state_t;

    function automatic logic [COL_W-1:0] low_ones(input int unsigned bits);
        logic [COL_W-1:0] m;
        m = '0;
        for (int i = 0; i < COL_W; i++)
            if (i < int'(bits)) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_pkg::*;
(
    input  logic [CODE_W-1:0] len_code,
    input  logic              ilv,
    output burst_cfg_t        cfg
);
    always_comb begin
        cfg.mask = '0;
        cfg.page = 1'b0;
        cfg.bad  = 1'b0;
        unique case (len_code)
            LEN_1:    cfg.mask = low_ones(0);
            LEN_2:    cfg.mask = low_ones(1);
            LEN_4:    cfg.mask = low_ones(2);
            LEN_8:    cfg.mask = low_ones(3);
            LEN_PAGE: begin
                cfg.mask = '1;
                cfg.page = 1'b1;
                cfg.bad  = ilv;
            end
            default:  cfg.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             term,
    input  logic             ilv,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg,
    input  logic             at_end,
    output burst_state_t     st,
    output logic             err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            err_q <= 1'b0;
        end else if (start) begin
            err_q   <= cfg.bad;
            st.run  <= !cfg.bad;
            st.ilv  <= ilv;
            st.page <= cfg.page;
            st.base <= start_col;
            st.beat <= '0;
            st.mask <= cfg.mask;
        end else begin
            err_q <= 1'b0;
            if (term || at_end)
                st.run <= 1'b0;
            else if (st.run)
                st.beat <= st.beat + 1'b1;
        end
    end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
(
    input  burst_state_t     st,
    output logic [COL_W-1:0] col,
    output logic             last
);
    logic [COL_W-1:0] low_seq, low_ilv, low_sel;

    always_comb begin
        low_seq = st.base + st.beat;
        low_ilv = st.base ^ st.beat;
        low_sel = st.ilv ? low_ilv : low_seq;
        col     = (st.base & ~st.mask) | (low_sel & st.mask);
        last    = st.run && !st.page && (st.beat == st.mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             type_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    burst_cfg_t   cfg;
    burst_state_t st;
    logic         last_w;

    burst_cfg_decode u_dec (
        .len_code (len_code_i),
        .ilv      (type_i),
        .cfg      (cfg)
    );

    burst_beat_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .term      (term_i),
        .ilv       (type_i),
        .start_col (start_col_i),
        .cfg       (cfg),
        .at_end    (last_w),
        .st        (st),
        .err_q     (err_o)
    );

    burst_addr_map u_map (
        .st   (st),
        .col  (col_o),
        .last (last_w)
    );

    assign valid_o = st.run;
    assign last_o  = last_w;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             type_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic legal;
    assign legal = (len_code_i <= 3'd3) || (len_code_i == 3'd7 && !type_i);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !valid_o && !err_o && !last_o) // R1
        else $error("reset state");
    AST_START_BEAT0: assert property (@(posedge clk) disable iff (rst)
        (start_i && legal) |=> valid_o && col_o == $past(start_col_i)) // R2
        else $error("start beat 0");
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o) // R5
        else $error("last ends");
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst) last_o |-> valid_o) // R5
        else $error("last without valid");
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && !term_i) |=> valid_o && col_o != $past(col_o)) // R6
        else $error("step");
    AST_BAD_ERR: assert property (@(posedge clk) disable iff (rst)
        (start_i && !legal) |=> err_o && !valid_o) // R7
        else $error("illegal start");
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> !err_o) // R7
        else $error("err pulse");
    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !valid_o) // R8
        else $error("terminate");
endmodule

bind burst_col_gen burst_col_gen_chk u_chk (.*);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
    import burst_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [2:0]       len_code_i;
    logic             type_i;
    logic             term_i;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;

    // bench reference state
    logic             m_v, m_err, m_ilv, m_page;
    logic [COL_W-1:0] m_base, m_n, m_mask;

    always #4 clk = ~clk;

    burst_col_gen uut (.*);

    function automatic logic legal_f(input logic [2:0] c, input logic t);
        return (c <= 3'd3) || (c == 3'd7 && !t);
    endfunction

    function automatic logic [COL_W-1:0] mask_f(input logic [2:0] c);
        if (c == 3'd7) return '1;
        return COL_W'((1 << c) - 1);
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] b,
        input logic [COL_W-1:0] n, input logic [COL_W-1:0] m, input logic il);
        logic [COL_W-1:0] lo;
        lo = il ? (b ^ n) : COL_W'(b + n);
        return (b & ~m) | (lo & m);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_v <= 1'b0; m_err <= 1'b0; m_n <= '0;
            m_base <= '0; m_mask <= '0; m_ilv <= 1'b0; m_page <= 1'b0;
        end else if (start_i) begin
            m_err  <= !legal_f(len_code_i, type_i);
            m_v    <= legal_f(len_code_i, type_i);
            m_base <= start_col_i;
            m_n    <= '0;
            m_mask <= mask_f(len_code_i);
            m_ilv  <= type_i;
            m_page <= (len_code_i == 3'd7);
        end else begin
            m_err <= 1'b0;
            if (term_i) m_v <= 1'b0;
            else if (m_v && !m_page && m_n == m_mask) m_v <= 1'b0;
            else if (m_v) m_n <= m_n + 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " valid"}, 32'(valid_o), 32'(m_v));
        chk({tag, " err"}, 32'(err_o), 32'(m_err));
        chk({tag, " last"}, 32'(last_o), 32'(m_v && !m_page && m_n == m_mask));
        if (m_v) chk({tag, " col"}, 32'(col_o), 32'(exp_col(m_base, m_n, m_mask, m_ilv)));
    endtask

    task automatic idle();
        start_i = 0; term_i = 0;
    endtask

    task automatic go(input logic [COL_W-1:0] c, input logic [2:0] l, input logic t);
        start_i = 1; start_col_i = c; len_code_i = l; type_i = t; term_i = 0;
    endtask

    task automatic step_expect(input string tag, input logic [COL_W-1:0] col,
                               input logic v, input logic lst);
        @(negedge clk);
        chk({tag, " valid"}, 32'(valid_o), 32'(v));
        chk({tag, " last"}, 32'(last_o), 32'(lst));
        if (v) chk({tag, " col"}, 32'(col_o), 32'(col));
        check_all(tag);
        idle();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; idle(); start_col_i = '0; len_code_i = '0; type_i = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(valid_o), 0);
        chk("R1 reset err", 32'(err_o), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset last", 32'(last_o), 0);

        // R3 sequential BL8 from 13: 13,14,15,8,9,10,11,12
        go(8'd13, 3'd3, 0);
        step_expect("R2 seq beat0", 8'd13, 1, 0);
        step_expect("R3 seq", 8'd14, 1, 0);
        step_expect("R3 seq", 8'd15, 1, 0);
        step_expect("R3 seq wrap", 8'd8, 1, 0);
        step_expect("R3 seq", 8'd9, 1, 0);
        step_expect("R3 seq", 8'd10, 1, 0);
        step_expect("R3 seq", 8'd11, 1, 0);
        step_expect("R5 seq last", 8'd12, 1, 1);
        step_expect("R5 after last", 8'd0, 0, 0);

        // R4 interleave BL4 from 0x45: 45,44,47,46
        go(8'h45, 3'd2, 1);
        step_expect("R4 ilv", 8'h45, 1, 0);
        step_expect("R4 ilv", 8'h44, 1, 0);
        step_expect("R4 ilv", 8'h47, 1, 0);
        step_expect("R5 ilv last", 8'h46, 1, 1);
        step_expect("R5 ilv end", 8'h00, 0, 0);

        // R2 single beat
        go(8'd77, 3'd0, 0);
        step_expect("R2 BL1", 8'd77, 1, 1);
        step_expect("R5 BL1 end", 8'd0, 0, 0);

        // R6 full page wraps through 0, then R8 terminate
        go(8'd254, 3'd7, 0);
        step_expect("R6 page", 8'd254, 1, 0);
        step_expect("R6 page", 8'd255, 1, 0);
        step_expect("R6 page wrap", 8'd0, 1, 0);
        step_expect("R6 page", 8'd1, 1, 0);
        term_i = 1;
        step_expect("R8 term", 8'd0, 0, 0);

        // R7 illegal combo cancels running burst
        go(8'd3, 3'd3, 0);
        step_expect("R2 start", 8'd3, 1, 0);
        go(8'd9, 3'd7, 1);
        @(negedge clk);
        chk("R7 err", 32'(err_o), 1);
        chk("R7 no valid", 32'(valid_o), 0);
        idle();
        @(negedge clk);
        chk("R7 err one cycle", 32'(err_o), 0);
        go(8'd9, 3'd5, 0);
        @(negedge clk);
        chk("R7 reserved err", 32'(err_o), 1);
        idle();

        // R9 replace mid-burst, start beats terminate
        go(8'd32, 3'd3, 0);
        step_expect("R9 first", 8'd32, 1, 0);
        step_expect("R9 first", 8'd33, 1, 0);
        go(8'd66, 3'd1, 1); term_i = 1;
        step_expect("R9 replaced", 8'd66, 1, 0);
        step_expect("R9 replaced", 8'd67, 1, 1);

        // random mix, R3 R4 R5 R6 R7 R8 R9 against the model
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] codes [6];
            codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd4};
            @(negedge clk);
            check_all("R9 random");
            start_i     = ($urandom % 8) == 0;
            term_i      = ($urandom % 20) == 0;
            start_col_i = COL_W'($urandom);
            len_code_i  = codes[$urandom % 6];
            type_i      = ($urandom % 3) == 0;
        end
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule